// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block derives the serial clock of an SPI master from a fast main clock. The main clock first passes through a prescaler, whose ratio is a selectable power of two: 2, 4, 8 or 16. The prescaler output then drives an even divider that divides by 2×(N+1). Nothing is divided as a real clock. The prescaler makes a one-cycle enable, and every register stays in the main clock domain.

A shift engine raises `run_i` for the duration of a transfer. It uses `lead_o` and `trail_o` to know when to launch and capture data. These are one-cycle strobes that coincide with the cycle in which `sclk_o` leaves its idle level or returns to it. The divide field has a floor of 4. The divider settings and the clock polarity are captured when a transfer starts, so software may rewrite them at any time.

Top module: `spi_sclk_gen`

## Requirements
- R1: After reset, `sclk_o`, `lead_o` and `trail_o` are all 0.
- R2: While `run_i` is low, `sclk_o` equals the value `cpol_i` had at the previous clock edge, and neither strobe is asserted.
- R3: While running, each half-period of `sclk_o` lasts (N+1)×(2<<P) main-clock cycles, where P is `div_i` and N is the effective divide value. The first transition comes exactly one half-period after the clock edge that samples `run_i` rising.
- R4: A `brg_i` value below 4 behaves exactly like 4.
- R5: The extreme settings give a full serial period of 20 main cycles (P=0, N=4) and of 2048 main cycles (P=3, N=63).
- R6: `div_i`, `brg_i` and `cpol_i` are sampled only in the cycle where `run_i` rises. Changes to them during a transfer affect neither timing nor idle level.
- R7: `lead_o` pulses for one cycle in each cycle where `sclk_o` has just left the idle level. `trail_o` pulses in each cycle where `sclk_o` has just returned to it. Strobes alternate, starting with `lead_o`.
- R8: Lowering `run_i` returns `sclk_o` to idle on the next edge. A later rise of `run_i` restarts timing from zero.
- R9: `lead_o` and `trail_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High while a transfer runs |
| cpol_i | input | 1 | Idle level of the serial clock |
| div_i | input | 2 | Prescale select P, ratio 2<<P |
| brg_i | input | 6 | Divide value N, floored at 4 |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | Strobe: serial clock has just left idle |
| trail_o | output | 1 | Strobe: serial clock has just returned to idle |

## Verification
The embedded assertions check on every cycle that:
- the strobes are exclusive and match the level `sclk_o` has just taken;
- any running transition of `sclk_o` carries a strobe;
- the counters stay within the captured bounds;
- the captured settings hold between starts;
- the idle level follows `cpol_i` whenever `run_i` is low.

Only the bench scenarios can show the absolute edge timing for each prescale and divide pair, including the floor on the divide value. They also show that settings rewritten mid-transfer are ignored, and that timing restarts cleanly after `run_i` is dropped partway through a half-period.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  localparam int unsigned SCLK_DIV_W   = 2;
  localparam int unsigned SCLK_BRG_W   = 6;
  localparam int unsigned SCLK_BRG_MIN = 4;
endpackage

// File: rtl/sclk_cfg_latch.sv
module sclk_cfg_latch #(
  parameter int unsigned DIV_W   = 2,
  parameter int unsigned BRG_W   = 6,
  parameter int unsigned BRG_MIN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [BRG_W-1:0] brg_i,
  input  logic             cpol_i,
  output logic [DIV_W-1:0] div_o,
  output logic [BRG_W-1:0] brg_o,
  output logic             idle_o
);
  localparam logic [BRG_W-1:0] BRG_FLOOR = BRG_W'(BRG_MIN);

  logic [BRG_W-1:0] brg_eff;

  generate
    if (BRG_MIN > 0) begin : g_floor
      assign brg_eff = (brg_i < BRG_FLOOR) ? BRG_FLOOR : brg_i;
    end else begin : g_nofloor
      assign brg_eff = brg_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o  <= '0;
      brg_o  <= BRG_FLOOR;
      idle_o <= 1'b0;
    end else if (load_i) begin
      div_o  <= div_i;
      brg_o  <= brg_eff;
      idle_o <= cpol_i;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable({div_o, brg_o, idle_o})) else $error("cfg changed without load"); // R6
  AST_BRG_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (brg_i < BRG_FLOOR) |=> brg_o == BRG_FLOOR) else $error("floor not applied"); // R4
endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int unsigned PRE_W = 1 << DIV_W;

  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] pre_max;
  logic [PRE_W-1:0] cnt_q;

  assign span    = (PRE_W+1)'(2) << div_i;
  assign pre_max = PRE_W'(span - (PRE_W+1)'(1));
  assign tick_o  = en_i && (cnt_q == pre_max);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (en_i)      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= pre_max) else $error("prescaler past terminal"); // R3
endmodule

// File: rtl/sclk_half_timer.sv
module sclk_half_timer #(
  parameter int unsigned BRG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_ld_i,
  input  logic             idle_lvl_i,
  input  logic             pol_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [BRG_W-1:0] brg_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic [BRG_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sclk_o  <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else begin
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
      if (idle_ld_i) begin
        cnt_q  <= '0;
        sclk_o <= idle_lvl_i;
      end else if (en_i && tick_i) begin
        if (cnt_q == brg_i) begin
          cnt_q  <= '0;
          sclk_o <= ~sclk_o;
          if (sclk_o == pol_i) lead_o  <= 1'b1;
          else                 trail_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && trail_o)) else $error("both strobes"); // R9
  AST_LEAD_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> sclk_o != pol_i) else $error("lead at idle level"); // R7
  AST_TRAIL_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |-> sclk_o == pol_i) else $error("trail off idle level"); // R7
  AST_EDGE_STROBED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) && (sclk_o != $past(sclk_o)) |-> (lead_o || trail_o)) else $error("edge without strobe"); // R7
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= brg_i) else $error("half counter past limit"); // R3
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int unsigned DIV_W   = SCLK_DIV_W,
  parameter int unsigned BRG_W   = SCLK_BRG_W,
  parameter int unsigned BRG_MIN = SCLK_BRG_MIN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cpol_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [BRG_W-1:0] brg_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic             active_q;
  logic             start;
  logic             en;
  logic             tick;
  logic [DIV_W-1:0] div_l;
  logic [BRG_W-1:0] brg_l;
  logic             idle_l;

  assign start = run_i && !active_q;
  assign en    = run_i && active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= run_i;
  end

  sclk_cfg_latch #(
    .DIV_W  (DIV_W),
    .BRG_W  (BRG_W),
    .BRG_MIN(BRG_MIN)
  ) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(start),
    .div_i (div_i),
    .brg_i (brg_i),
    .cpol_i(cpol_i),
    .div_o (div_l),
    .brg_o (brg_l),
    .idle_o(idle_l)
  );

  sclk_prescaler #(
    .DIV_W(DIV_W)
  ) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!en),
    .en_i  (en),
    .div_i (div_l),
    .tick_o(tick)
  );

  sclk_half_timer #(
    .BRG_W(BRG_W)
  ) u_half (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idle_ld_i (!en),
    .idle_lvl_i(cpol_i),
    .pol_i     (idle_l),
    .en_i      (en),
    .tick_i    (tick),
    .brg_i     (brg_l),
    .sclk_o    (sclk_o),
    .lead_o    (lead_o),
    .trail_o   (trail_o)
  );

  AST_IDLE_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (sclk_o == $past(cpol_i)) && !lead_o && !trail_o) else $error("not idle"); // R2
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_i) |-> ##1 !lead_o && !trail_o) else $error("strobe after stop"); // R8
endmodule

// File: tb/spi_sclk_gen_test.sv
module spi_sclk_gen_test;
  localparam int WD_LIMIT = 150000;
  localparam int NVEC = 8;
  // div, brg, cpol, expected half-period in main cycles
  localparam int VEC [NVEC][4] = '{
    '{0,  4, 0,   10},
    '{3, 63, 1, 1024},
    '{1,  7, 0,   32},
    '{2,  0, 1,   40},
    '{0,  3, 0,   10},
    '{1, 10, 1,   44},
    '{3,  5, 0,   96},
    '{2, 20, 1,  168}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       cpol = 1'b0;
  logic [1:0] div = '0;
  logic [5:0] brg = 6'd4;
  logic       sclk, lead, trail;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_sclk_gen uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .run_i  (run),
    .cpol_i (cpol),
    .div_i  (div),
    .brg_i  (brg),
    .sclk_o (sclk),
    .lead_o (lead),
    .trail_o(trail)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected <= %0d", cyc, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // start a transfer and time the first three strobes relative to the sampling edge
  task automatic run_case(input int d, input int b, input int c, input int h,
                          input bit change_mid, input string tag);
    int first_lead = -1, first_trail = -1, second_lead = -1;
    int both = 0, badlvl = 0;
    @(negedge clk);
    div = d[1:0]; brg = b[5:0]; cpol = c[0]; run = 1'b1;
    @(posedge clk);
    if (change_mid) begin
      @(negedge clk);
      div = ~div; brg = 6'd63 - brg; cpol = ~cpol;
    end
    for (int k = 1; k <= 3*h + 20; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (lead && trail) both++;
      if (lead) begin
        if (sclk == c[0]) badlvl++;
        if (first_lead < 0) first_lead = k;
        else if (second_lead < 0) second_lead = k;
      end
      if (trail) begin
        if (sclk != c[0]) badlvl++;
        if (first_trail < 0) first_trail = k;
      end
      if (second_lead >= 0) break;
    end
    chk(first_lead == h, {tag, " first leading edge"}, first_lead, h);
    chk(first_trail == 2*h, {tag, " R7 trailing edge"}, first_trail, 2*h);
    chk(second_lead == 3*h, {tag, " R3 second leading edge"}, second_lead, 3*h);
    chk(badlvl == 0, {tag, " R7 strobe level"}, badlvl, 0);
    chk(both == 0, {tag, " R9 strobe overlap"}, both, 0);
    @(negedge clk);
    run = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(sclk == cpol, {tag, " R8 idle after stop"}, sclk, cpol);
  endtask

  initial begin
    // R1 reset state
    #1;
    chk(sclk == 1'b0 && !lead && !trail, "R1 reset outputs", {sclk, lead, trail}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b0 && !lead && !trail, "R1 after release", {sclk, lead, trail}, 0);

    // R2 idle follows cpol, no strobes
    begin
      int strobes = 0;
      cpol = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk(sclk == 1'b1, "R2 idle high", sclk, 1);
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        div = 2'(i); brg = 6'(i);
        if (lead || trail) strobes++;
      end
      chk(strobes == 0, "R2 no strobes while idle", strobes, 0);
      cpol = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(sclk == 1'b0, "R2 idle low", sclk, 0);
    end

    // table: R3, R4 (rows 3,4), R5 (rows 0,1)
    for (int v = 0; v < NVEC; v++)
      run_case(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b0, $sformatf("R3/R4/R5 vec%0d", v));

    // R5 full period at the extremes
    chk(2*VEC[0][3] == 20, "R5 fastest period", 2*VEC[0][3], 20);
    chk(2*VEC[1][3] == 2048, "R5 slowest period", 2*VEC[1][3], 2048);

    // R6 rewrite settings mid-transfer
    run_case(0, 4, 0, 10, 1'b1, "R6 mid-run change");
    run_case(1, 2, 1, 20, 1'b1, "R6 mid-run change floor");

    // R8 stop partway, then restart
    begin
      int first_lead = -1;
      @(negedge clk);
      div = 2'd0; brg = 6'd4; cpol = 1'b0; run = 1'b1;
      @(posedge clk);
      repeat (15) @(posedge clk);
      @(negedge clk);
      chk(sclk == 1'b1, "R8 mid half-period high", sclk, 1);
      run = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(sclk == 1'b0 && !trail, "R8 stop forces idle", {sclk, trail}, 0);
      run = 1'b1;
      @(posedge clk);
      for (int k = 1; k <= 40; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (lead && first_lead < 0) first_lead = k;
      end
      chk(first_lead == 10, "R8 restart timing", first_lead, 10);
      @(negedge clk);
      run = 1'b0;
    end

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule